// File: doc/BRIEF.md
# Raster Line Timing Generator with Down-Counting Position

This block produces the horizontal timing of a raster display pipeline. A position counter starts each line at a programmed line total and steps down by one on every pixel clock. When it reaches zero it reloads. Three programmable windows hang off that count: horizontal sync, the horizontal active-video window and a pixel-clock gating window. Each window opens when the count equals its start value and closes when the count equals its stop value.

The active-video output is active-low. It is asserted only while both the externally supplied vertical active input (also active-low) and the horizontal active window are asserted. When pixel-clock gating is enabled, the active window must sit exactly five counts after the gating window. A status bit reports any programming that breaks this rule.

Software writes the line total, the three start/stop pairs and a control word through a simple synchronous register port. All written values wait in pending registers and are copied into the working set only when the counter reloads. As a result, no line ever mixes old and new settings.

Top module: `hline_timing`

## Requirements
- R1: After a synchronous reset, every register reads zero, `hcount` is 0, `eol` and `cfg_err` are 0, and `hsync`, `de_n` and `pclk_en` are 1.
- R2: While `hcount` is nonzero, it decreases by exactly one per clock. On the clock after `hcount` is 0, it holds the line total.
- R3: `eol` is 1 in exactly those cycles that directly follow a cycle in which `hcount` was 0. With a line total of 0, it therefore stays high.
- R4: The sync window turns on in the cycle where `hcount` equals its start value and turns off in the cycle where `hcount` equals its stop value. Control bit 0 selects the polarity of `hsync`: 0 gives active-low (low inside the window), 1 gives active-high.
- R5: A window whose start value equals its stop value is never on.
- R6: `de_n` is 0 in a cycle only if `vact_n` was 0 at the preceding clock edge and the active window is on in that cycle. Otherwise `de_n` is 1.
- R7: When control bit 1 (gating enable) is 1, `pclk_en` follows the gating window. When it is 0, `pclk_en` is 1.
- R8: One clock after the pending settings have gating enabled with an active start or stop that is not the matching gating value plus 5 (modulo 2^CW), `cfg_err` and status bit 0 read 1. Otherwise they read 0.
- R9: Register addresses are: 0 line total (bits CW-1:0), 1 sync, 2 active, 3 gating, 4 control, 5 status (read-only; writes to it are ignored). A window register holds stop in bits 16+CW-1:16 and start in bits CW-1:0. Unused bits read 0. `rd_data` shows the pending value selected by `rd_addr` one clock later.
- R10: A write changes the generated timing only from the line that starts after the next reload. The line in progress keeps its old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Registered read data |
| vact_n | input | 1 | Vertical active window, active-low |
| hcount | output | CW | Horizontal down-count position |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| de_n | output | 1 | Combined active video, active-low |
| pclk_en | output | 1 | Pixel clock enable |
| eol | output | 1 | First cycle of each new line |
| cfg_err | output | 1 | Gating-offset rule violated by pending settings |

## Verification
The bench builds the block with CW=6, which keeps every line short. Many complete lines, reloads and mid-line register rewrites therefore fit in a short run. The narrow count also makes the modulo-64 wrap of the plus-five gating rule reachable: a gating start of 60 pairs with an active start of 1. A line total of 0, and windows that straddle the reload point, can be reached at this width as well.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
  localparam int REG_AW   = 3;
  localparam int NWIN     = 3;
  localparam int W_SYNC   = 0;
  localparam int W_ACT    = 1;
  localparam int W_GATE   = 2;
  localparam int STOP_LSB = 16;
  localparam int CTRL_POL  = 0;
  localparam int CTRL_GATE = 1;

  typedef enum logic [REG_AW-1:0] {
    A_TOTAL = 3'd0,
    A_SYNC  = 3'd1,
    A_ACT   = 3'd2,
    A_GATE  = 3'd3,
    A_CTRL  = 3'd4,
    A_STAT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/hrt_counter.sv
module hrt_counter #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] total_nx,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx,
  output logic          reload
);
  assign reload = (cnt == '0);
  assign cnt_nx = reload ? total_nx : cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  // R2: a nonzero count steps down by one
  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hrt_window.sv
module hrt_window #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] start_nx,
  input  logic [CW-1:0] stop_nx,
  output logic          win_nx,
  output logic          win_q
);
  always_comb begin
    if (start_nx == stop_nx)     win_nx = 1'b0;
    else if (cnt_nx == start_nx) win_nx = 1'b1;
    else if (cnt_nx == stop_nx)  win_nx = 1'b0;
    else                         win_nx = win_q;
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= win_nx;
  end

  // R5: equal compare values keep the window shut
  p_off_r5: assert property (@(posedge clk) disable iff (rst)
    (start_nx == stop_nx) |=> !win_q);
endmodule

// File: rtl/hrt_regs.sv
module hrt_regs
  import hrt_pkg::*;
#(
  parameter int CW   = 11,
  parameter int LEAD = 5,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [REG_AW-1:0]         wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [REG_AW-1:0]         rd_addr,
  output logic [DW-1:0]             rd_data,
  input  logic                      reload,
  output logic [CW-1:0]             total_nx,
  output logic [NWIN-1:0][CW-1:0]   start_nx,
  output logic [NWIN-1:0][CW-1:0]   stop_nx,
  output logic                      pol_nx,
  output logic                      gate_en_nx,
  output logic                      err
);
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD);

  logic [CW-1:0]           p_total, l_total;
  logic [NWIN-1:0][CW-1:0] p_start, p_stop, l_start, l_stop;
  logic                    p_pol, p_gen, l_pol, l_gen;
  logic                    err_d;
  logic [DW-1:0]           rd_word;

  // pending (software-visible) set
  always_ff @(posedge clk) begin
    if (rst) begin
      p_total <= '0;
      p_start <= '0;
      p_stop  <= '0;
      p_pol   <= 1'b0;
      p_gen   <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_TOTAL: p_total <= wr_data[CW-1:0];
        A_CTRL: begin
          p_pol <= wr_data[CTRL_POL];
          p_gen <= wr_data[CTRL_GATE];
        end
        default: begin
          for (int i = 0; i < NWIN; i++) begin
            if (wr_addr == REG_AW'(i + 1)) begin
              p_start[i] <= wr_data[CW-1:0];
              p_stop[i]  <= wr_data[STOP_LSB +: CW];
            end
          end
        end
      endcase
    end
  end

  // working set, swapped only on a line reload
  always_ff @(posedge clk) begin
    if (rst) begin
      l_total <= '0;
      l_start <= '0;
      l_stop  <= '0;
      l_pol   <= 1'b0;
      l_gen   <= 1'b0;
    end else if (reload) begin
      l_total <= p_total;
      l_start <= p_start;
      l_stop  <= p_stop;
      l_pol   <= p_pol;
      l_gen   <= p_gen;
    end
  end

  assign total_nx   = reload ? p_total : l_total;
  assign start_nx   = reload ? p_start : l_start;
  assign stop_nx    = reload ? p_stop  : l_stop;
  assign pol_nx     = reload ? p_pol   : l_pol;
  assign gate_en_nx = reload ? p_gen   : l_gen;

  // plus-LEAD placement rule between active and gating windows
  assign err_d = p_gen &&
                 ((p_start[W_ACT] != p_start[W_GATE] + LEAD_C) ||
                  (p_stop[W_ACT]  != p_stop[W_GATE]  + LEAD_C));

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err_d;
  end

  always_comb begin
    rd_word = '0;
    case (reg_addr_e'(rd_addr))
      A_TOTAL: rd_word[CW-1:0] = p_total;
      A_CTRL: begin
        rd_word[CTRL_POL]  = p_pol;
        rd_word[CTRL_GATE] = p_gen;
      end
      A_STAT:  rd_word[0] = err;
      default: begin
        for (int i = 0; i < NWIN; i++) begin
          if (rd_addr == REG_AW'(i + 1)) begin
            rd_word[CW-1:0]          = p_start[i];
            rd_word[STOP_LSB +: CW]  = p_stop[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

  // R10: working values hold between reloads
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!reload) |=> ($stable(l_total) && $stable(l_start) && $stable(l_stop) &&
                   $stable(l_pol) && $stable(l_gen)));
  // R8: no error flagged while gating is off in the pending set
  p_err_r8: assert property (@(posedge clk) disable iff (rst)
    (!p_gen) |=> !err);
endmodule

// File: rtl/hline_timing.sv
module hline_timing
  import hrt_pkg::*;
#(
  parameter int CW   = 11,
  parameter int LEAD = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  input  logic          vact_n,
  output logic [CW-1:0] hcount,
  output logic          hsync,
  output logic          de_n,
  output logic          pclk_en,
  output logic          eol,
  output logic          cfg_err
);
  logic [CW-1:0]           total_nx, cnt_nx;
  logic [NWIN-1:0][CW-1:0] start_nx, stop_nx;
  logic [NWIN-1:0]         win_nx, win_q;
  logic                    pol_nx, gate_en_nx, reload;

  hrt_regs #(.CW(CW), .LEAD(LEAD), .DW(32)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reload(reload),
    .total_nx(total_nx), .start_nx(start_nx), .stop_nx(stop_nx),
    .pol_nx(pol_nx), .gate_en_nx(gate_en_nx), .err(cfg_err)
  );

  hrt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .total_nx(total_nx),
    .cnt(hcount), .cnt_nx(cnt_nx), .reload(reload)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    hrt_window #(.CW(CW)) u_win (
      .clk(clk), .rst(rst), .cnt_nx(cnt_nx),
      .start_nx(start_nx[g]), .stop_nx(stop_nx[g]),
      .win_nx(win_nx[g]), .win_q(win_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync   <= 1'b1;
      de_n    <= 1'b1;
      pclk_en <= 1'b1;
      eol     <= 1'b0;
    end else begin
      hsync   <= pol_nx ? win_nx[W_SYNC] : ~win_nx[W_SYNC];
      de_n    <= vact_n | ~win_nx[W_ACT];
      pclk_en <= ~gate_en_nx | win_nx[W_GATE];
      eol     <= reload;
    end
  end

  // R3: strobe follows a zero count, and only that
  p_eol_r3: assert property (@(posedge clk) disable iff (rst)
    (hcount == '0) |=> eol);
  p_noeol_r3: assert property (@(posedge clk) disable iff (rst)
    (hcount != '0) |=> !eol);
  // R6: vertical blanking forces video off
  p_de_r6: assert property (@(posedge clk) disable iff (rst)
    vact_n |=> de_n);
  // R7: clock runs freely when gating is off
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!gate_en_nx) |=> pclk_en);
endmodule

// File: tb/hline_timing_bench.sv
module hline_timing_bench;
  localparam int CW = 6;
  localparam int M  = 1 << CW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        vact_n = 1'b1;
  logic [CW-1:0] hcount;
  logic        hsync, de_n, pclk_en, eol, cfg_err;

  always #2.5 clk = ~clk;

  hline_timing #(.CW(CW), .LEAD(5)) u_hline_timing (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vact_n(vact_n), .hcount(hcount),
    .hsync(hsync), .de_n(de_n), .pclk_en(pclk_en), .eol(eol), .cfg_err(cfg_err)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, vpat_on = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int p_tot, l_tot, p_pol, l_pol, p_gen, l_gen, m_cnt;
  int p_s[3], p_p[3], l_s[3], l_p[3], m_w[3];
  int e_hsync, e_de, e_pen, e_eol, e_err, e_rd;
  bit m_ok = 0;

  function automatic int rd_model(int a);
    case (a)
      0: return p_tot;
      1, 2, 3: return (p_p[a-1] << 16) | p_s[a-1];
      4: return p_pol | (p_gen << 1);
      5: return e_err;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p_tot = 0; l_tot = 0; p_pol = 0; l_pol = 0; p_gen = 0; l_gen = 0; m_cnt = 0;
      for (int i = 0; i < 3; i++) begin
        p_s[i] = 0; p_p[i] = 0; l_s[i] = 0; l_p[i] = 0; m_w[i] = 0;
      end
      e_hsync = 1; e_de = 1; e_pen = 1; e_eol = 0; e_err = 0; e_rd = 0;
      m_ok = 1;
    end else begin
      bit rl;
      e_rd = rd_model(int'(rd_addr));
      e_err = (p_gen != 0) && ((p_s[1] != (p_s[2] + 5) % M) || (p_p[1] != (p_p[2] + 5) % M));
      rl = (m_cnt == 0);
      e_eol = rl;
      if (rl) begin
        l_tot = p_tot; l_pol = p_pol; l_gen = p_gen;
        for (int i = 0; i < 3; i++) begin l_s[i] = p_s[i]; l_p[i] = p_p[i]; end
        m_cnt = l_tot;
      end else m_cnt = m_cnt - 1;
      for (int i = 0; i < 3; i++) begin
        if (l_s[i] == l_p[i]) m_w[i] = 0;
        else if (m_cnt == l_s[i]) m_w[i] = 1;
        else if (m_cnt == l_p[i]) m_w[i] = 0;
      end
      e_hsync = l_pol ? m_w[0] : !m_w[0];
      e_de    = (vact_n || !m_w[1]) ? 1 : 0;
      e_pen   = (!l_gen || m_w[2]) ? 1 : 0;
      if (wr_en) begin
        case (int'(wr_addr))
          0: p_tot = wr_data[CW-1:0];
          1, 2, 3: begin
            p_s[wr_addr-1] = wr_data[CW-1:0];
            p_p[wr_addr-1] = wr_data[16 +: CW];
          end
          4: begin p_pol = wr_data[0]; p_gen = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_ok && !done) begin
      chk("R2 hcount", int'(hcount), m_cnt);
      chk("R3 eol", int'(eol), e_eol);
      chk("R4 R5 R10 hsync", int'(hsync), e_hsync);
      chk("R6 de_n", int'(de_n), e_de);
      chk("R7 pclk_en", int'(pclk_en), e_pen);
      chk("R8 cfg_err", int'(cfg_err), e_err);
      chk("R9 rd_data", int'(rd_data), e_rd);
    end
  end

  // vertical active pattern
  always @(negedge clk) begin
    cyc++;
    if (vpat_on) vact_n <= ((cyc % 29) < 6);
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic win(int a, int start, int stop);
    wr(a, (32'(stop) << 16) | 32'(start));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state (one edge after release, counter reloaded to total 0)
    chk("R1 hsync", int'(hsync), 1);
    chk("R1 de_n", int'(de_n), 1);
    chk("R1 pclk_en", int'(pclk_en), 1);
    chk("R1 cfg_err", int'(cfg_err), 0);
    chk("R1 hcount", int'(hcount), 0);
    for (int a = 0; a < 6; a++) rd(a, 0, "R1 register reset");
    // R3: line total 0 gives a strobe every cycle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 eol with total 0", int'(eol), 1);
    end

    vpat_on = 1;
    wr(0, 19);
    win(1, 17, 12);
    win(2, 14, 3);
    rd(1, (12 << 16) | 17, "R9 sync readback");
    repeat (70) @(negedge clk);

    // R10: rewrite mid-line; model checks that the current line is unchanged
    while (hcount != 10) @(negedge clk);
    win(1, 8, 2);
    repeat (60) @(negedge clk);

    // R4: active-high polarity
    wr(4, 1);
    repeat (50) @(negedge clk);

    // R5: equal start and stop, with vertical active held low
    vpat_on = 0;
    vact_n = 1'b0;
    win(2, 5, 5);
    repeat (25) @(negedge clk);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      chk("R5 de_n stays high", int'(de_n), 1);
    end
    vpat_on = 1;

    // R8: gating rule violated, then satisfied
    win(2, 14, 3);
    win(3, 10, 4);
    wr(4, 2);
    @(negedge clk);
    chk("R8 err on misplaced window", int'(cfg_err), 1);
    rd(5, 1, "R8 status bit");
    win(2, 15, 9);
    @(negedge clk);
    chk("R8 err clears", int'(cfg_err), 0);
    repeat (50) @(negedge clk);

    // R8: modulo wrap of the plus-five rule, window across reload
    wr(0, 63);
    win(3, 60, 55);
    win(2, 1, 60);
    @(negedge clk);
    chk("R8 wrapped offset accepted", int'(cfg_err), 0);
    repeat (150) @(negedge clk);

    // R9: reserved bits read zero, status writes ignored
    wr(4, 32'hFFFF_FFFC);
    rd(4, 0, "R9 control reserved bits");
    wr(0, 32'hFFFF_FFFF);
    rd(0, M - 1, "R9 total reserved bits");
    wr(5, 32'hFFFF_FFFF);
    rd(5, 0, "R9 status write ignored");
    win(1, 40, 30);
    repeat (140) @(negedge clk);

    finish_run();
  end
endmodule